// File: doc/BRIEF.md
# Abort-Aware Load/Store Sequencer

This block carries out the narrow and paired memory transfers of a 32-bit register-file CPU: unsigned and signed byte and halfword loads, byte and halfword stores, and two-register (doubleword) loads and stores. The core hands it a decoded operation, the instruction word, the current base register value, a computed offset and the value or values to store. The block forms the access address in pre-indexed or post-indexed style and drives a data-memory port with a request/grant handshake. It then steps through one or two memory beats, each answered by a response that carries read data and an abort flag.

When the last response arrives, the block reports once, for a single cycle. The report says whether the instruction aborted, whether the base register is rewritten and with what value, and which destination registers take which loaded values. An abort anywhere in the instruction blocks all register writeback. A paired load gives up after an aborting first beat. A paired store always issues both beats and merges their abort flags. A parameter selects a core variant without paired transfers; on that variant a paired operation finishes as an empty operation.

Top module: `ldst_abort_seq`

## Requirements
- R1: The access address is base+offset when `pre_i`=1 and the plain base when `pre_i`=0. The base write value is always base+offset. The base is written on a non-aborting pre-indexed access only if instruction bit 21 is 1, and always on a non-aborting post-indexed access. The base index is instruction bits 19:16.
- R2: Halfword accesses (store halfword, load halfword, load signed halfword) issue `mem_size_o`=1 with address bit 0 forced to 0. Byte accesses use size 0 and word beats use size 2.
- R3: Loaded values are formed as follows. An unsigned byte load zero-extends bits 7:0 and an unsigned halfword load zero-extends bits 15:0. A signed byte load copies bit 7 into bits 31:8, and a signed halfword load copies bit 15 into bits 31:16. The destination index is instruction bits 15:12.
- R4: A paired transfer uses the register pair whose low index is the transfer index with bit 0 cleared. Its first beat uses the access address and the low register. Its second beat uses address+4 and the low index+1.
- R5: A paired load whose first beat aborts issues no second beat. Any abort in a paired load ends it without writeback.
- R6: A paired store always issues both beats: the low register value on beat one, the high register value on beat two. Its abort result is the OR of both beats' abort flags.
- R7: When any beat aborts, `abort_o` pulses together with `done_o`, and `base_we_o`, `dst_we_o` and `dst2_we_o` stay 0. Write enables and `abort_o` are only ever high in a `done_o` cycle.
- R8: With `HAS_DWORD`=0 a paired operation issues no memory request. It raises `done_o` in the cycle after acceptance, with no writes and no abort.
- R9: `mem_req_o` stays high with a stable address and direction until `mem_gnt_i`. Only one beat is outstanding at a time. No request is made while idle. `done_o` and the results appear exactly one cycle after the final response.
- R10: After reset `idle_o`=1 and `done_o`=`mem_req_o`=0. `start_i` is taken only while `idle_o`=1. The `op_i` codes are 0 store byte, 1 store halfword, 2 store pair, 3 load byte, 4 load halfword, 5 load signed byte, 6 load signed halfword, and 7 load pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (taken when idle) |
| idle_o | output | 1 | Sequencer idle, ready to accept |
| op_i | input | 3 | Operation code (R10) |
| pre_i | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| instr_i | input | 32 | Instruction word (bits 21, 19:16, 15:12 used) |
| base_val_i | input | 32 | Current base register value |
| offset_i | input | 32 | Computed offset |
| data_lo_i | input | 32 | Store value (transfer register, or low register of the pair) |
| data_hi_i | input | 32 | Store value of the high register of the pair |
| mem_req_o | output | 1 | Memory request valid |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | 1 = write |
| mem_size_o | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_addr_o | output | 32 | Access address |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | 32 | Response read data |
| mem_abort_i | input | 1 | Response abort flag |
| done_o | output | 1 | Operation finished (one cycle) |
| abort_o | output | 1 | Operation aborted |
| base_we_o | output | 1 | Write base register |
| base_idx_o | output | 4 | Base register index |
| base_data_o | output | 32 | New base value |
| dst_we_o | output | 1 | Write destination (low) register |
| dst_idx_o | output | 4 | Destination (low) index |
| dst_data_o | output | 32 | Destination (low) value |
| dst2_we_o | output | 1 | Write high register of a pair |
| dst2_idx_o | output | 4 | High register index |
| dst2_data_o | output | 32 | High register value |

## Verification
The first request rises in the cycle after `start_i` is taken and stays up until granted. Each response comes at the earliest one cycle after its grant. The report, meaning `done_o`, `abort_o`, the write enables and their data, is due exactly one cycle after the final response, and an empty paired operation reports one cycle after acceptance. The bench samples on the falling edge. It records the cycle of the last response seen by its memory model, waits for `done_o`, and checks that `done_o` arrived in the next cycle before comparing the reported values with its own model. Grant stalls of zero to two cycles and abort injection on either beat move the response cycle, so the check follows the logged response rather than a fixed delay.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [2:0] {
    OP_SB  = 3'd0,
    OP_SH  = 3'd1,
    OP_SD  = 3'd2,
    OP_LB  = 3'd3,
    OP_LH  = 3'd4,
    OP_LSB = 3'd5,
    OP_LSH = 3'd6,
    OP_LD  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } st_e;

  function automatic logic is_load(op_e op);
    return op >= OP_LB;
  endfunction

  function automatic logic is_pair(op_e op);
    return (op == OP_SD) || (op == OP_LD);
  endfunction

  function automatic size_e op_size(op_e op);
    case (op)
      OP_SB, OP_LB, OP_LSB: return SZ_BYTE;
      OP_SH, OP_LH, OP_LSH: return SZ_HALF;
      default:              return SZ_WORD;
    endcase
  endfunction
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_e             op_i,
  input  logic            pre_i,
  input  logic            beat_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] off_i,
  output logic [XLEN-1:0] addr_o,
  output logic [1:0]      size_o,
  output logic [XLEN-1:0] new_base_o
);
  localparam int unsigned STEP = XLEN / 8;

  logic [XLEN-1:0] sum, eff, beat_addr;

  assign sum       = base_i + off_i;
  assign eff       = pre_i ? sum : base_i;
  assign beat_addr = beat_i ? eff + XLEN'(STEP) : eff;

  always_comb begin
    addr_o = beat_addr;
    if (op_size(op_i) == SZ_HALF) addr_o[0] = 1'b0;
  end

  assign size_o     = op_size(op_i);
  assign new_base_o = sum;
endmodule

// File: rtl/ldst_extend.sv
module ldst_extend
  import ldst_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_e             op_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] val_o
);
  always_comb begin
    case (op_i)
      OP_LB:   val_o = {{(XLEN-8){1'b0}}, rdata_i[7:0]};
      OP_LH:   val_o = {{(XLEN-16){1'b0}}, rdata_i[15:0]};
      OP_LSB:  val_o = {{(XLEN-8){rdata_i[7]}}, rdata_i[7:0]};
      OP_LSH:  val_o = {{(XLEN-16){rdata_i[15]}}, rdata_i[15:0]};
      default: val_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int RIDX_W    = 4,
  parameter bit HAS_DWORD = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              idle_o,
  input  op_e               op_i,
  input  logic              pre_i,
  input  logic              wb_i,
  input  logic [RIDX_W-1:0] rt_i,
  input  logic [RIDX_W-1:0] rb_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   off_i,
  input  logic [XLEN-1:0]   lo_i,
  input  logic [XLEN-1:0]   hi_i,
  output op_e               op_o,
  output logic              pre_o,
  output logic              beat_o,
  output logic [XLEN-1:0]   base_o,
  output logic [XLEN-1:0]   off_o,
  input  logic [XLEN-1:0]   new_base_i,
  input  logic [XLEN-1:0]   ext_i,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  input  logic              mem_abort_i,
  output logic              done_o,
  output logic              abort_o,
  output logic              base_we_o,
  output logic [RIDX_W-1:0] base_idx_o,
  output logic [XLEN-1:0]   base_data_o,
  output logic              dst_we_o,
  output logic [RIDX_W-1:0] dst_idx_o,
  output logic [XLEN-1:0]   dst_data_o,
  output logic              dst2_we_o,
  output logic [RIDX_W-1:0] dst2_idx_o,
  output logic [XLEN-1:0]   dst2_data_o
);
  st_e               st_q;
  op_e               op_q;
  logic              pre_q, wb_q, beat_q, acc_q;
  logic [RIDX_W-1:0] rt_q, rb_q;
  logic [XLEN-1:0]   base_q, off_q, lo_q, hi_q, first_q;

  logic accept, pair_q, pair_in, ab_now, more;

  assign accept  = start_i && (st_q == ST_IDLE);
  assign pair_in = is_pair(op_i);
  assign pair_q  = is_pair(op_q);
  assign ab_now  = acc_q | mem_abort_i;
  // store pair always continues; load pair continues only on clean first beat
  assign more    = pair_q && !beat_q && (!is_load(op_q) || !mem_abort_i);

  assign idle_o      = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_REQ);
  assign mem_we_o    = !is_load(op_q);
  assign mem_wdata_o = beat_q ? hi_q : lo_q;
  assign op_o        = op_q;
  assign pre_o       = pre_q;
  assign beat_o      = beat_q;
  assign base_o      = base_q;
  assign off_o       = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_LB;
      pre_q       <= 1'b0;
      wb_q        <= 1'b0;
      beat_q      <= 1'b0;
      acc_q       <= 1'b0;
      rt_q        <= '0;
      rb_q        <= '0;
      base_q      <= '0;
      off_q       <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      first_q     <= '0;
      done_o      <= 1'b0;
      abort_o     <= 1'b0;
      base_we_o   <= 1'b0;
      base_idx_o  <= '0;
      base_data_o <= '0;
      dst_we_o    <= 1'b0;
      dst_idx_o   <= '0;
      dst_data_o  <= '0;
      dst2_we_o   <= 1'b0;
      dst2_idx_o  <= '0;
      dst2_data_o <= '0;
    end else begin
      done_o    <= 1'b0;
      abort_o   <= 1'b0;
      base_we_o <= 1'b0;
      dst_we_o  <= 1'b0;
      dst2_we_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (pair_in && !HAS_DWORD) begin
              done_o <= 1'b1;  // unsupported pair: empty operation
            end else begin
              st_q   <= ST_REQ;
              op_q   <= op_i;
              pre_q  <= pre_i;
              wb_q   <= wb_i;
              rt_q   <= rt_i;
              rb_q   <= rb_i;
              base_q <= base_i;
              off_q  <= off_i;
              lo_q   <= lo_i;
              hi_q   <= hi_i;
              beat_q <= 1'b0;
              acc_q  <= 1'b0;
            end
          end
        end
        ST_REQ: begin
          if (mem_gnt_i) st_q <= ST_RSP;
        end
        ST_RSP: begin
          if (mem_rvalid_i) begin
            if (more) begin
              st_q    <= ST_REQ;
              beat_q  <= 1'b1;
              acc_q   <= ab_now;
              first_q <= mem_rdata_i;
            end else begin
              st_q        <= ST_IDLE;
              done_o      <= 1'b1;
              abort_o     <= ab_now;
              base_we_o   <= !ab_now && (!pre_q || wb_q);
              base_idx_o  <= rb_q;
              base_data_o <= new_base_i;
              dst_we_o    <= !ab_now && is_load(op_q);
              dst_idx_o   <= pair_q ? {rt_q[RIDX_W-1:1], 1'b0} : rt_q;
              dst_data_o  <= pair_q ? first_q : ext_i;
              dst2_we_o   <= !ab_now && is_load(op_q) && pair_q;
              dst2_idx_o  <= {rt_q[RIDX_W-1:1], 1'b1};
              dst2_data_o <= mem_rdata_i;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldst_abort_seq.sv
module ldst_abort_seq
  import ldst_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_DWORD = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            idle_o,
  input  logic [2:0]      op_i,
  input  logic            pre_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] base_val_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic [XLEN-1:0] data_lo_i,
  input  logic [XLEN-1:0] data_hi_i,
  output logic            mem_req_o,
  input  logic            mem_gnt_i,
  output logic            mem_we_o,
  output logic [1:0]      mem_size_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_abort_i,
  output logic            done_o,
  output logic            abort_o,
  output logic            base_we_o,
  output logic [3:0]      base_idx_o,
  output logic [XLEN-1:0] base_data_o,
  output logic            dst_we_o,
  output logic [3:0]      dst_idx_o,
  output logic [XLEN-1:0] dst_data_o,
  output logic            dst2_we_o,
  output logic [3:0]      dst2_idx_o,
  output logic [XLEN-1:0] dst2_data_o
);
  localparam int RIDX_W = 4;
  localparam int WB_BIT = 21;
  localparam int RB_LSB = 16;
  localparam int RT_LSB = 12;

  op_e             op_q;
  logic            pre_q, beat_q;
  logic [XLEN-1:0] base_q, off_q, new_base, ext_val;
  logic            unused_instr;

  assign unused_instr = ^{instr_i[31:22], instr_i[20], instr_i[11:0]};

  ldst_ctrl #(.XLEN(XLEN), .RIDX_W(RIDX_W), .HAS_DWORD(HAS_DWORD)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .idle_o      (idle_o),
    .op_i        (op_e'(op_i)),
    .pre_i       (pre_i),
    .wb_i        (instr_i[WB_BIT]),
    .rt_i        (instr_i[RT_LSB +: RIDX_W]),
    .rb_i        (instr_i[RB_LSB +: RIDX_W]),
    .base_i      (base_val_i),
    .off_i       (offset_i),
    .lo_i        (data_lo_i),
    .hi_i        (data_hi_i),
    .op_o        (op_q),
    .pre_o       (pre_q),
    .beat_o      (beat_q),
    .base_o      (base_q),
    .off_o       (off_q),
    .new_base_i  (new_base),
    .ext_i       (ext_val),
    .mem_req_o   (mem_req_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_abort_i (mem_abort_i),
    .done_o      (done_o),
    .abort_o     (abort_o),
    .base_we_o   (base_we_o),
    .base_idx_o  (base_idx_o),
    .base_data_o (base_data_o),
    .dst_we_o    (dst_we_o),
    .dst_idx_o   (dst_idx_o),
    .dst_data_o  (dst_data_o),
    .dst2_we_o   (dst2_we_o),
    .dst2_idx_o  (dst2_idx_o),
    .dst2_data_o (dst2_data_o)
  );

  ldst_addr_gen #(.XLEN(XLEN)) u_addr (
    .op_i      (op_q),
    .pre_i     (pre_q),
    .beat_i    (beat_q),
    .base_i    (base_q),
    .off_i     (off_q),
    .addr_o    (mem_addr_o),
    .size_o    (mem_size_o),
    .new_base_o(new_base)
  );

  ldst_extend #(.XLEN(XLEN)) u_ext (
    .op_i   (op_q),
    .rdata_i(mem_rdata_i),
    .val_o  (ext_val)
  );
endmodule

// File: rtl/ldst_abort_seq_chk.sv
module ldst_abort_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            idle_o,
  input logic            mem_req_o,
  input logic            mem_gnt_i,
  input logic            mem_we_o,
  input logic [1:0]      mem_size_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            done_o,
  input logic            abort_o,
  input logic            base_we_o,
  input logic            dst_we_o,
  input logic [3:0]      dst_idx_o,
  input logic            dst2_we_o,
  input logic [3:0]      dst2_idx_o
);
  AST_ABORT_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !(base_we_o || dst_we_o || dst2_we_o)); // R7

  AST_WB_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_o || dst_we_o || dst2_we_o || abort_o) |-> done_o); // R7

  AST_HALF_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_size_o == 2'd1) |-> !mem_addr_o[0]); // R2

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_req_o); // R9

  AST_PAIR_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst2_we_o |-> (dst_we_o && !dst_idx_o[0] && dst2_idx_o == (dst_idx_o | 4'd1))); // R4
endmodule

bind ldst_abort_seq ldst_abort_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idle_o    (idle_o),
  .mem_req_o (mem_req_o),
  .mem_gnt_i (mem_gnt_i),
  .mem_we_o  (mem_we_o),
  .mem_size_o(mem_size_o),
  .mem_addr_o(mem_addr_o),
  .done_o    (done_o),
  .abort_o   (abort_o),
  .base_we_o (base_we_o),
  .dst_we_o  (dst_we_o),
  .dst_idx_o (dst_idx_o),
  .dst2_we_o (dst2_we_o),
  .dst2_idx_o(dst2_idx_o)
);

// File: tb/sim_ldst_abort_seq.sv
`timescale 1ns/1ps
module sim_ldst_abort_seq;
  typedef struct packed {
    logic [2:0]  op;
    logic        pre;
    logic        wb;
    logic [3:0]  rt;
    logic [3:0]  rb;
    logic [31:0] base;
    logic [31:0] off;
    logic [1:0]  am;     // abort mask per beat
    logic [1:0]  beats;  // expected beats
    logic        ab;     // expected abort
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 1'b1, 1'b1, 4'd3,  4'd1, 32'h1000_0080, 32'h0000_0004, 2'b00, 2'd1, 1'b0},
    '{3'd5, 1'b0, 1'b0, 4'd2,  4'd4, 32'h2000_00F0, 32'h0000_0010, 2'b00, 2'd1, 1'b0},
    '{3'd6, 1'b1, 1'b0, 4'd5,  4'd6, 32'h3000_8001, 32'h0000_0100, 2'b00, 2'd1, 1'b0},
    '{3'd4, 1'b0, 1'b0, 4'd6,  4'd7, 32'h4000_9003, 32'h0000_0002, 2'b00, 2'd1, 1'b0},
    '{3'd0, 1'b1, 1'b1, 4'd1,  4'd2, 32'h5000_0000, 32'h0000_0008, 2'b01, 2'd1, 1'b1},
    '{3'd1, 1'b0, 1'b0, 4'd7,  4'd3, 32'h6000_0011, 32'hFFFF_FFFE, 2'b00, 2'd1, 1'b0},
    '{3'd7, 1'b1, 1'b1, 4'd9,  4'd10, 32'h7000_0000, 32'h0000_0020, 2'b00, 2'd2, 1'b0},
    '{3'd7, 1'b0, 1'b0, 4'd4,  4'd11, 32'h7100_0000, 32'h0000_0040, 2'b01, 2'd1, 1'b1},
    '{3'd7, 1'b1, 1'b1, 4'd6,  4'd12, 32'h7200_0000, 32'h0000_0008, 2'b10, 2'd2, 1'b1},
    '{3'd2, 1'b1, 1'b1, 4'd2,  4'd13, 32'h7300_0000, 32'h0000_0010, 2'b01, 2'd2, 1'b1},
    '{3'd2, 1'b0, 1'b0, 4'd4,  4'd0,  32'h7400_0100, 32'h0000_0030, 2'b00, 2'd2, 1'b0},
    '{3'd2, 1'b0, 1'b0, 4'd11, 4'd5,  32'h7500_0200, 32'h0000_0004, 2'b10, 2'd2, 1'b1},
    '{3'd5, 1'b1, 1'b1, 4'd8,  4'd9,  32'h7600_0080, 32'h0000_0001, 2'b01, 2'd1, 1'b1},
    '{3'd3, 1'b0, 1'b0, 4'd14, 4'd15, 32'h7700_007F, 32'h0000_0003, 2'b00, 2'd1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 1'b0, start1 = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        pre = 1'b0;
  logic [31:0] instr = '0, base = '0, off = '0, dlo = '0, dhi = '0;
  logic        mem_req, mem_we, mem_rvalid = 1'b0, mem_abort = 1'b0, mem_gnt;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        idle, done, abort, base_we, dst_we, dst2_we;
  logic [3:0]  base_idx, dst_idx, dst2_idx;
  logic [31:0] base_data, dst_data, dst2_data;

  logic        idle1, done1, abort1, base_we1, dst_we1, dst2_we1, req1, we1;
  logic [3:0]  base_idx1, dst_idx1, dst2_idx1;
  logic [31:0] base_data1, dst_data1, dst2_data1, addr1, wdata1;
  logic [1:0]  size1;

  int nchk = 0, nerr = 0;
  int cyc = 0, last_rsp = 0, stall_cnt = 0, stall_n = 0, nbeat = 0;
  logic [1:0]  amask = 2'b00;
  logic        clr = 1'b0, req1_seen = 1'b0;
  logic [31:0] la [2];
  logic [31:0] lw [2];

  ldst_abort_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .idle_o(idle), .op_i(op), .pre_i(pre),
    .instr_i(instr), .base_val_i(base), .offset_i(off), .data_lo_i(dlo), .data_hi_i(dhi),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_we_o(mem_we), .mem_size_o(mem_size),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_abort_i(mem_abort), .done_o(done), .abort_o(abort),
    .base_we_o(base_we), .base_idx_o(base_idx), .base_data_o(base_data),
    .dst_we_o(dst_we), .dst_idx_o(dst_idx), .dst_data_o(dst_data),
    .dst2_we_o(dst2_we), .dst2_idx_o(dst2_idx), .dst2_data_o(dst2_data));

  ldst_abort_seq #(.HAS_DWORD(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start1), .idle_o(idle1), .op_i(op), .pre_i(pre),
    .instr_i(instr), .base_val_i(base), .offset_i(off), .data_lo_i(dlo), .data_hi_i(dhi),
    .mem_req_o(req1), .mem_gnt_i(1'b0), .mem_we_o(we1), .mem_size_o(size1),
    .mem_addr_o(addr1), .mem_wdata_o(wdata1), .mem_rvalid_i(1'b0),
    .mem_rdata_i(32'h0), .mem_abort_i(1'b0), .done_o(done1), .abort_o(abort1),
    .base_we_o(base_we1), .base_idx_o(base_idx1), .base_data_o(base_data1),
    .dst_we_o(dst_we1), .dst_idx_o(dst_idx1), .dst_data_o(dst_data1),
    .dst2_we_o(dst2_we1), .dst2_idx_o(dst2_idx1), .dst2_data_o(dst2_data1));

  function automatic logic [31:0] rfn(input logic [31:0] a);
    return {a[31:24] ^ 8'h3C, ~a[7:0], a[15:8], a[7:0]};
  endfunction

  // memory model: grant after stall_n waiting cycles, respond one cycle after grant
  assign mem_gnt = mem_req && (stall_cnt >= stall_n);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req1) req1_seen <= 1'b1;
    if (mem_rvalid) last_rsp <= cyc;
    mem_rvalid <= mem_req && mem_gnt;
    mem_rdata  <= rfn(mem_addr);
    mem_abort  <= (nbeat < 2) ? amask[nbeat] : 1'b0;
    if (mem_req && !mem_gnt) stall_cnt <= stall_cnt + 1;
    else stall_cnt <= 0;
    if (clr) nbeat <= 0;
    else if (mem_req && mem_gnt) begin
      if (nbeat < 2) begin
        la[nbeat] <= mem_addr;
        lw[nbeat] <= mem_wdata;
      end
      nbeat <= nbeat + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int stall);
    logic [31:0] eff, exp_lo;
    logic        ld, pair, ab;
    int          w;
    @(negedge clk);
    op    = v.op;
    pre   = v.pre;
    instr = '0;
    instr[21] = v.wb;
    instr[19:16] = v.rb;
    instr[15:12] = v.rt;
    base  = v.base;
    off   = v.off;
    dlo   = 32'hC0DE_0000 | {28'h0, v.rt};
    dhi   = 32'hBEEF_0000 | {28'h0, v.rt};
    amask = v.am;
    stall_n = stall;
    start = 1'b1;
    clr   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    clr   = 1'b0;
    w = 0;
    while (!done && w < 60) begin
      @(negedge clk);
      w++;
    end
    ld   = (v.op >= 3'd3);
    pair = (v.op == 3'd2) || (v.op == 3'd7);
    ab   = pair ? |v.am : v.am[0];
    eff  = v.pre ? v.base + v.off : v.base;
    if (v.op == 3'd1 || v.op == 3'd4 || v.op == 3'd6) eff[0] = 1'b0;
    check("R9", "done after last response", 32'(cyc), 32'(last_rsp + 1));
    check("R7", "abort flag", {31'h0, abort}, {31'h0, ab});
    check("R7", "table abort", {31'h0, ab}, {31'h0, v.ab});
    check(pair ? (ld ? "R5" : "R6") : "R9", "beat count", 32'(nbeat), {30'h0, v.beats});
    check("R1", "first address", la[0], eff);
    if (v.beats == 2'd2) check("R4", "second address", la[1], eff + 32'd4);
    if (!ld) begin
      check("R6", "first store data", lw[0], dlo);
      if (pair) check("R6", "second store data", lw[1], dhi);
    end
    check("R1", "base write enable", {31'h0, base_we}, {31'h0, !ab && (!v.pre || v.wb)});
    if (!ab) begin
      check("R1", "base index", {28'h0, base_idx}, {28'h0, v.rb});
      check("R1", "base value", base_data, v.base + v.off);
    end
    check("R7", "dst write enable", {31'h0, dst_we}, {31'h0, ld && !ab});
    check("R7", "dst2 write enable", {31'h0, dst2_we}, {31'h0, ld && pair && !ab});
    if (ld && !ab) begin
      case (v.op)
        3'd3: exp_lo = {24'h0, rfn(eff)[7:0]};
        3'd4: exp_lo = {16'h0, rfn(eff)[15:0]};
        3'd5: exp_lo = {{24{rfn(eff)[7]}}, rfn(eff)[7:0]};
        3'd6: exp_lo = {{16{rfn(eff)[15]}}, rfn(eff)[15:0]};
        default: exp_lo = rfn(eff);
      endcase
      check(pair ? "R4" : "R3", "dst value", dst_data, exp_lo);
      check(pair ? "R4" : "R3", "dst index", {28'h0, dst_idx},
            {28'h0, pair ? {v.rt[3:1], 1'b0} : v.rt});
      if (pair) begin
        check("R4", "dst2 value", dst2_data, rfn(eff + 32'd4));
        check("R4", "dst2 index", {28'h0, dst2_idx}, {28'h0, v.rt[3:1], 1'b1});
      end
    end
    @(negedge clk);
    check("R9", "single-cycle done", {31'h0, done}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset idle", {31'h0, idle}, 32'h1);
    check("R10", "reset done", {31'h0, done}, 32'h0);
    check("R10", "reset request", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);
    // unsupported pair on the variant without paired transfers
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      op    = (k == 0) ? 3'd7 : 3'd2;
      pre   = 1'b1;
      instr = 32'h0023_4000;
      base  = 32'h0000_1000;
      off   = 32'h0000_0008;
      start1 = 1'b1;
      @(negedge clk);
      start1 = 1'b0;
      check("R8", "empty pair done", {31'h0, done1}, 32'h1);
      check("R8", "empty pair writes", {29'h0, base_we1, dst_we1, dst2_we1}, 32'h0);
      check("R8", "empty pair abort", {31'h0, abort1}, 32'h0);
      check("R8", "empty pair request", {31'h0, req1_seen}, 32'h0);
    end
    // start ignored while busy: second pulse during a stalled request is dropped
    @(negedge clk);
    op = 3'd3; pre = 1'b0; instr = '0; base = 32'h0000_2000; off = '0;
    amask = 2'b00; stall_n = 3; start = 1'b1; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    base = 32'h0000_3000;
    check("R10", "busy not idle", {31'h0, idle}, 32'h0);
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R10", "busy start dropped", 32'(nbeat), 32'd1);
    check("R9", "stalled address held", la[0], 32'h0000_2000);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule